// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source and destination addresses for a single DMA channel. Software sets up a start source address, a start destination address, a step width and a direction bit for each side, and a beat count. It does this through a small word-wide register port. A start pulse copies the visible address registers into two working counters. The working counters drive the address outputs. Each completed beat moves both of them by their own step, upward or downward.

The visible registers stay frozen for the whole transfer. When the last beat finishes, they take the next address that would have been used, and a one-cycle done pulse marks that write-back. An abort ends the transfer at once. It writes the working addresses back as they stand and returns the block to idle without a done pulse. The bus protocol, data movement, request arbitration and interrupts belong to neighbouring logic.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, all four registers read 0, both direction bits read 0 (increment), busy_o and done_o are low, and both address outputs are 0.
- R2: Register select 0 is the source address and 1 is the destination address, both 32 bits. Select 2 is configuration: bits [7:0] hold the source step, [15:8] the destination step, bit 16 the source direction and bit 17 the destination direction (0 add, 1 subtract). Select 3 is the beat count in bits [15:0]. Unused bits read 0, and reads are combinational.
- R3: A start pulse while idle with a nonzero count raises busy_o. In the next cycle both address outputs equal the visible registers.
- R4: The cycle after a beat-done strobe in a busy cycle, src_addr_o has moved by the source step, added when bit 16 is 0 and subtracted when it is 1, modulo 2^32.
- R5: dst_addr_o moves the same way by the destination step under bit 17, independent of the source setting.
- R6: A step of 0 holds that address constant for the whole transfer, whatever its direction bit says.
- R7: While busy, the visible registers do not change, and register writes to every select are ignored.
- R8: On the beat that brings the count to zero, both visible registers take the next address (start ± count×step). In the following cycle busy_o is low and done_o is high for exactly one cycle.
- R9: While idle, beat strobes change neither the address outputs nor the registers, and cause no done pulse.
- R10: A start pulse with a count of 0 is ignored and the block stays idle.
- R11: An abort while busy writes the current working addresses to the visible registers, drops busy_o and gives no done pulse. An abort in the same cycle as a beat wins, and that beat does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| start_i | input | 1 | Start pulse |
| beat_done_i | input | 1 | One transfer beat completed |
| abort_i | input | 1 | Stop the running transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the final beat |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |

## Verification
Every result here is registered once. Busy and the loaded addresses appear in the cycle after the start edge. An advanced address appears in the cycle after the beat edge. Done, the dropped busy and the written-back visible registers all appear together in the cycle after the final beat or the abort. The bench drives every stimulus on a falling edge and holds it across one rising edge. It samples at the next falling edge, which is exactly one register stage later. Read-back is combinational, so it is sampled a moment after the select is set in that same cycle. The checker adds the matching one-cycle-later properties: step per beat, frozen registers, the done pulse width and the abort write-back.

// File: rtl/dma_agen_pkg.sv
`timescale 1ns/1ps
package dma_agen_pkg;
  localparam int unsigned REG_SEL_W = 2;
  typedef enum logic [REG_SEL_W-1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CFG = 2'd2,
    SEL_CNT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_agen_step.sv
`timescale 1ns/1ps
module dma_agen_step #(
  parameter int unsigned AW = 32,
  parameter int unsigned WW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  input  logic [WW-1:0] width_i,
  input  logic          dec_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] step;

  assign step   = AW'(width_i);
  assign next_o = dec_i ? addr_q - step : addr_q + step;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (adv_i)  addr_q <= next_o;
  end
endmodule

// File: rtl/dma_agen_ctrl.sv
`timescale 1ns/1ps
module dma_agen_ctrl #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          beat_i,
  input  logic          abort_i,
  input  logic [CW-1:0] count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          adv_o,
  output logic          wb_o,
  output logic          wb_next_o
);
  logic          busy_q, done_q, last;
  logic [CW-1:0] cnt_q;

  assign load_o    = !busy_q && start_i && (count_i != '0);
  assign adv_o     = busy_q && beat_i && !abort_i;
  assign last      = adv_o && (cnt_q == CW'(1));
  assign wb_next_o = last;
  assign wb_o      = last || (busy_q && abort_i);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= count_i;
      end else if (wb_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (adv_o) begin
        cnt_q  <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_agen_regs.sv
`timescale 1ns/1ps
module dma_agen_regs
  import dma_agen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned WW = 8,
  parameter int unsigned CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_SEL_W-1:0] sel_i,
  input  logic [AW-1:0]        wdata_i,
  output logic [AW-1:0]        rdata_o,
  input  logic                 busy_i,
  input  logic                 wb_i,
  input  logic [AW-1:0]        wb_src_i,
  input  logic [AW-1:0]        wb_dst_i,
  output logic [AW-1:0]        vis_src_o,
  output logic [AW-1:0]        vis_dst_o,
  output logic [WW-1:0]        src_w_o,
  output logic [WW-1:0]        dst_w_o,
  output logic                 src_dec_o,
  output logic                 dst_dec_o,
  output logic [CW-1:0]        count_o
);
  localparam int unsigned CFG_W = 2*WW + 2;

  logic wr_ok;
  logic unused_wdata;

  assign wr_ok        = we_i && !busy_i;
  assign unused_wdata = ^wdata_i[AW-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_src_o <= '0;
      vis_dst_o <= '0;
      src_w_o   <= '0;
      dst_w_o   <= '0;
      src_dec_o <= 1'b0;
      dst_dec_o <= 1'b0;
      count_o   <= '0;
    end else if (wb_i) begin
      vis_src_o <= wb_src_i;
      vis_dst_o <= wb_dst_i;
    end else if (wr_ok) begin
      unique case (reg_sel_e'(sel_i))
        SEL_SRC: vis_src_o <= wdata_i;
        SEL_DST: vis_dst_o <= wdata_i;
        SEL_CFG: begin
          src_w_o   <= wdata_i[WW-1:0];
          dst_w_o   <= wdata_i[2*WW-1:WW];
          src_dec_o <= wdata_i[2*WW];
          dst_dec_o <= wdata_i[2*WW+1];
        end
        SEL_CNT: count_o <= wdata_i[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_SRC: rdata_o = vis_src_o;
      SEL_DST: rdata_o = vis_dst_o;
      SEL_CFG: rdata_o = {{(AW-CFG_W){1'b0}}, dst_dec_o, src_dec_o, dst_w_o, src_w_o};
      SEL_CNT: rdata_o = {{(AW-CW){1'b0}}, count_o};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen
  import dma_agen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned WW = 8,
  parameter int unsigned CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_SEL_W-1:0] reg_addr_i,
  input  logic [AW-1:0]        reg_wdata_i,
  output logic [AW-1:0]        reg_rdata_o,
  input  logic                 start_i,
  input  logic                 beat_done_i,
  input  logic                 abort_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [AW-1:0]        src_addr_o,
  output logic [AW-1:0]        dst_addr_o
);
  localparam int unsigned NSIDE = 2;

  logic          load, adv, wb, wb_next;
  logic [AW-1:0] vis_src, vis_dst;
  logic [WW-1:0] src_w, dst_w;
  logic          src_dec, dst_dec;
  logic [CW-1:0] count;

  logic [AW-1:0] vis_a  [NSIDE];
  logic [WW-1:0] w_a    [NSIDE];
  logic          dec_a  [NSIDE];
  logic [AW-1:0] work_a [NSIDE];
  logic [AW-1:0] next_a [NSIDE];
  logic [AW-1:0] wb_a   [NSIDE];

  assign vis_a[0] = vis_src;
  assign vis_a[1] = vis_dst;
  assign w_a[0]   = src_w;
  assign w_a[1]   = dst_w;
  assign dec_a[0] = src_dec;
  assign dec_a[1] = dst_dec;

  dma_agen_ctrl #(.CW(CW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .beat_i    (beat_done_i),
    .abort_i   (abort_i),
    .count_i   (count),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .load_o    (load),
    .adv_o     (adv),
    .wb_o      (wb),
    .wb_next_o (wb_next)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_agen_step #(.AW(AW), .WW(WW)) u_step (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .load_addr_i (vis_a[s]),
      .adv_i       (adv),
      .width_i     (w_a[s]),
      .dec_i       (dec_a[s]),
      .addr_o      (work_a[s]),
      .next_o      (next_a[s])
    );
    // final beat stores the address after it; abort stores the current one
    assign wb_a[s] = wb_next ? next_a[s] : work_a[s];
  end

  dma_agen_regs #(.AW(AW), .WW(WW), .CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy_o),
    .wb_i      (wb),
    .wb_src_i  (wb_a[0]),
    .wb_dst_i  (wb_a[1]),
    .vis_src_o (vis_src),
    .vis_dst_o (vis_dst),
    .src_w_o   (src_w),
    .dst_w_o   (dst_w),
    .src_dec_o (src_dec),
    .dst_dec_o (dst_dec),
    .count_o   (count)
  );

  assign src_addr_o = work_a[0];
  assign dst_addr_o = work_a[1];
endmodule

// File: rtl/dma_addr_gen_chk.sv
`timescale 1ns/1ps
module dma_addr_gen_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned WW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          beat_done_i,
  input logic          abort_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o,
  input logic [AW-1:0] vis_src,
  input logic [AW-1:0] vis_dst,
  input logic [WW-1:0] src_w,
  input logic [WW-1:0] dst_w,
  input logic          src_dec,
  input logic          dst_dec
);
  AST_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && beat_done_i && !abort_i |=> src_addr_o ==
      ($past(src_dec) ? $past(src_addr_o) - AW'($past(src_w))
                      : $past(src_addr_o) + AW'($past(src_w)))); // R4

  AST_DST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && beat_done_i && !abort_i |=> dst_addr_o ==
      ($past(dst_dec) ? $past(dst_addr_o) - AW'($past(dst_w))
                      : $past(dst_addr_o) + AW'($past(dst_w)))); // R5

  AST_VIS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(vis_src) && $stable(vis_dst)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && vis_src == src_addr_o && vis_dst == dst_addr_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(src_addr_o) && $stable(dst_addr_o) && !done_o); // R9

  AST_ABORT_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && abort_i |=> !busy_o && !done_o &&
      vis_src == $past(src_addr_o) && vis_dst == $past(dst_addr_o)); // R11
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .WW(WW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .beat_done_i (beat_done_i),
  .abort_i     (abort_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .src_addr_o  (src_addr_o),
  .dst_addr_o  (dst_addr_o),
  .vis_src     (vis_src),
  .vis_dst     (vis_dst),
  .src_w       (src_w),
  .dst_w       (dst_w),
  .src_dec     (src_dec),
  .dst_dec     (dst_dec)
);

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        start_i = 1'b0, beat_done_i = 1'b0, abort_i = 1'b0;
  logic        busy_o, done_o;
  logic [31:0] src_addr_o, dst_addr_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  dma_addr_gen dut_i (.*);

  localparam int NV = 6;
  localparam logic [31:0] V_SRC [NV] = '{32'h1000, 32'h8000, 32'hFFFF_FFF8, 32'h4000, 32'hA0, 32'h100};
  localparam logic [31:0] V_DST [NV] = '{32'h2000, 32'h9000, 32'h10,        32'h5000, 32'hB0, 32'h200};
  localparam logic [7:0]  V_SW  [NV] = '{8'd4, 8'd1, 8'd4, 8'd0, 8'd255, 8'd16};
  localparam logic [7:0]  V_DW  [NV] = '{8'd4, 8'd2, 8'd8, 8'd0, 8'd0,   8'd16};
  localparam bit          V_SD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit          V_DD  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int          V_CNT [NV] = '{5, 3, 4, 6, 2, 1};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input bit s, input bit b, input bit ab);
    start_i = s; beat_done_i = b; abort_i = ab;
    @(negedge clk_i);
    start_i = 1'b0; beat_done_i = 1'b0; abort_i = 1'b0;
  endtask

  function automatic logic [31:0] stp(input logic [31:0] a, input logic [7:0] w, input bit dec);
    return dec ? a - {24'd0, w} : a + {24'd0, w};
  endfunction

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [7:0] sw,
                       input logic [7:0] dw, input bit sd, input bit dd, input int cnt);
    wr(2'd0, s);
    wr(2'd1, d);
    wr(2'd2, {14'd0, dd, sd, dw, sw});
    wr(2'd3, cnt);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, es, ed, hold_s;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      check("R1 reg", r, 32'd0);
    end
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    check("R1 src_addr", src_addr_o, 32'd0);
    check("R1 dst_addr", dst_addr_o, 32'd0);

    // R2 field layout and width masking
    wr(2'd2, 32'hFFFF_0A05);
    rd(2'd2, r); check("R2 cfg readback", r, 32'h0003_0A05);
    wr(2'd3, 32'h0001_2345);
    rd(2'd3, r); check("R2 count readback", r, 32'h0000_2345);

    // vector table
    for (int v = 0; v < NV; v++) begin
      string ts, tdst;
      ts   = (V_SW[v] == 0) ? "R6 src" : "R4 src";
      tdst = (V_DW[v] == 0) ? "R6 dst" : "R5 dst";
      setup(V_SRC[v], V_DST[v], V_SW[v], V_DW[v], V_SD[v], V_DD[v], V_CNT[v]);
      rd(2'd2, r); check("R2 cfg", r, {14'd0, V_DD[v], V_SD[v], V_DW[v], V_SW[v]});
      pulse(1, 0, 0);
      check("R3 busy", {31'd0, busy_o}, 32'd1);
      check("R3 src load", src_addr_o, V_SRC[v]);
      check("R3 dst load", dst_addr_o, V_DST[v]);
      es = V_SRC[v]; ed = V_DST[v];
      for (int k = 0; k < V_CNT[v]; k++) begin
        if (k % 2 == 1) begin
          @(negedge clk_i);
          check({ts, " gap"}, src_addr_o, es);
        end
        pulse(0, 1, 0);
        es = stp(es, V_SW[v], V_SD[v]);
        ed = stp(ed, V_DW[v], V_DD[v]);
        check(ts, src_addr_o, es);
        check(tdst, dst_addr_o, ed);
        if (k < V_CNT[v] - 1) begin
          rd(2'd0, r); check("R7 src frozen", r, V_SRC[v]);
          check("R8 done early", {31'd0, done_o}, 32'd0);
        end
      end
      check("R8 done", {31'd0, done_o}, 32'd1);
      check("R8 busy low", {31'd0, busy_o}, 32'd0);
      rd(2'd0, r); check("R8 src wb", r, es);
      rd(2'd1, r); check("R8 dst wb", r, ed);
      @(negedge clk_i);
      check("R8 done width", {31'd0, done_o}, 32'd0);
    end

    // R9 beats while idle
    hold_s = src_addr_o;
    pulse(0, 1, 0);
    pulse(0, 1, 0);
    check("R9 src hold", src_addr_o, hold_s);
    check("R9 no done", {31'd0, done_o}, 32'd0);
    rd(2'd0, r); check("R9 vis hold", r, hold_s);

    // R10 start with zero count
    setup(32'h700, 32'h800, 8'd4, 8'd4, 0, 0, 0);
    pulse(1, 0, 0);
    check("R10 busy", {31'd0, busy_o}, 32'd0);
    check("R10 src_addr", src_addr_o, hold_s);

    // R7 writes ignored while busy
    setup(32'h1000, 32'h6000, 8'd4, 8'd4, 0, 0, 3);
    pulse(1, 0, 0);
    wr(2'd0, 32'hDEAD_BEEF);
    wr(2'd2, 32'h0003_1010);
    wr(2'd3, 32'd9);
    rd(2'd0, r); check("R7 src write blocked", r, 32'h1000);
    rd(2'd2, r); check("R7 cfg write blocked", r, 32'h0000_0404);
    rd(2'd3, r); check("R7 cnt write blocked", r, 32'd3);
    for (int k = 0; k < 3; k++) pulse(0, 1, 0);
    check("R7 done", {31'd0, done_o}, 32'd1);
    rd(2'd0, r); check("R7 final src", r, 32'h100C);

    // R11 abort alone
    setup(32'h2000, 32'h3000, 8'd4, 8'd4, 0, 0, 5);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    pulse(0, 1, 0);
    pulse(0, 0, 1);
    check("R11 busy", {31'd0, busy_o}, 32'd0);
    check("R11 no done", {31'd0, done_o}, 32'd0);
    rd(2'd0, r); check("R11 src wb", r, 32'h2008);
    rd(2'd1, r); check("R11 dst wb", r, 32'h3008);

    // R11 abort with beat in same cycle
    pulse(1, 0, 0);
    check("R11 reload", src_addr_o, 32'h2008);
    pulse(0, 1, 0);
    pulse(0, 1, 1);
    check("R11 abort wins busy", {31'd0, busy_o}, 32'd0);
    check("R11 abort wins addr", src_addr_o, 32'h200C);
    rd(2'd0, r); check("R11 abort wins src wb", r, 32'h200C);
    rd(2'd1, r); check("R11 abort wins dst wb", r, 32'h300C);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule